// File: doc/BRIEF.md
# Console Buffer DMA Engine

This engine moves a block of bytes between system memory and a console's byte streams. A small register front end holds a 64-bit buffer address and a 32-bit byte count, and a command word picks the direction and starts the transfer.

In the memory-to-console direction, the engine reads the whole count from memory, one byte at a time, and hands each byte to a transmit stream with valid/ready flow control. In the console-to-memory direction, it pops bytes from a receive FIFO and writes them to consecutive memory addresses. It stops at the count or when the FIFO runs dry, whichever comes first.

Each transfer finishes with a one-cycle done pulse. Alongside it, the engine reports whether the receive FIFO is empty, so the surrounding logic can drop its receive interrupt. The memory side is a single-outstanding byte port: a request is held until the response arrives.

Top module: `cbuf_dma`

## Requirements
- R1: A write to offset 0x10 replaces the whole 64-bit pointer, with bits 63:32 cleared. A write to offset 0x18 replaces only bits 63:32. A write to offset 0x14 sets the 32-bit length. `ptr_o` and `len_o` show the stored values.
- R2: Writing command value 2 to offset 0x08 while idle reads `len` bytes from addresses `ptr`, `ptr+1`, … (full 64-bit carry). Each byte is emitted on `tx_data_o` in address order.
- R3: The memory-to-console transfer is split into chunks of at most `CHUNK` bytes. The address and remaining count carry over across chunk boundaries, so the byte stream has no gaps and no repeats.
- R4: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold. No byte is lost or duplicated.
- R5: Command value 3 writes the FIFO head byte (`rx_data_i`) to consecutive addresses starting at `ptr`. `rx_pop_o` pulses exactly in the cycle each memory write is accepted.
- R6: A command-3 transfer stops after `len` bytes or as soon as the FIFO is empty, whichever comes first.
- R7: A length of zero makes no memory request for either command. `done_o` is high in the cycle right after the command write.
- R8: `busy_o` is high from the cycle after an accepted command through the cycle of `done_o`. `done_o` lasts exactly one cycle. Command writes while busy are ignored.
- R9: `done_rx_empty_o` is high together with `done_o` exactly when the receive FIFO is empty at completion.
- R10: A transfer never modifies the stored pointer or length; it works on internal copies. Register writes during a transfer update `ptr_o`/`len_o` but do not affect the running transfer.
- R11: A memory request holds `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stable until `mem_rsp_i` is sampled high.
- R12: After reset the engine is idle, the pointer and length are zero, and no memory request, transmit byte or done is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| ptr_o | output | 64 | Stored buffer pointer |
| len_o | output | 32 | Stored buffer length |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| done_rx_empty_o | output | 1 | Receive FIFO empty, qualified by done |
| mem_req_o | output | 1 | Memory request, held until response |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_rsp_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 8 | Read byte, valid with response |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Transmit sink accepts byte |
| rx_empty_i | input | 1 | Receive FIFO empty |
| rx_data_i | input | 8 | Receive FIFO head byte |
| rx_pop_o | output | 1 | Pop receive FIFO head |

## Verification
A wrong working address or remaining count appears at the ports on the very next memory request. It shows up as a wrong transmitted byte, because read data is a function of the address, or as a misplaced write. A miscounted length shows up only at the end, as one byte too many or too few before the done pulse. A wrong chunk counter is invisible in the byte stream unless it corrupts the address carry, so its bound is guarded internally. A missed or extra FIFO pop shows up on the next written byte as a data mismatch, and in the pop strobe during the same response cycle.

// File: rtl/cbuf_dma_pkg.sv
package cbuf_dma_pkg;
  localparam int unsigned REG_AW = 6;
  localparam int unsigned PTR_W  = 64;
  localparam int unsigned LEN_W  = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;

  localparam logic [REG_AW-1:0] OFF_CMD    = 6'h08;
  localparam logic [REG_AW-1:0] OFF_PTR_LO = 6'h10;
  localparam logic [REG_AW-1:0] OFF_LEN    = 6'h14;
  localparam logic [REG_AW-1:0] OFF_PTR_HI = 6'h18;

  localparam logic [WORD_W-1:0] CMD_MEM_TO_TX = 32'd2;
  localparam logic [WORD_W-1:0] CMD_RX_TO_MEM = 32'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_REQ,
    ST_W_TX,
    ST_W_NEXT,
    ST_R_CHK,
    ST_R_REQ,
    ST_DONE
  } state_e;
endpackage

// File: rtl/cbuf_dma_regs.sv
module cbuf_dma_regs
  import cbuf_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              idle_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              start_tx_o,
  output logic              start_mem_o
);
  localparam int unsigned HI_W = PTR_W - WORD_W;

  logic [PTR_W-1:0] ptr_q;
  logic [LEN_W-1:0] len_q;
  logic             cmd_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      len_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        OFF_PTR_LO: ptr_q <= {{HI_W{1'b0}}, wdata_i};
        OFF_PTR_HI: ptr_q[PTR_W-1:WORD_W] <= wdata_i[HI_W-1:0];
        OFF_LEN:    len_q <= wdata_i[LEN_W-1:0];
        default:    ;
      endcase
    end
  end

  assign cmd_wr      = we_i && (addr_i == OFF_CMD) && idle_i;
  assign start_tx_o  = cmd_wr && (wdata_i == CMD_MEM_TO_TX);
  assign start_mem_o = cmd_wr && (wdata_i == CMD_RX_TO_MEM);
  assign ptr_o       = ptr_q;
  assign len_o       = len_q;

  a_r10_regs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ptr_q) && $stable(len_q));
  a_r1_hi_keeps_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == OFF_PTR_HI |=> ptr_q[WORD_W-1:0] == $past(ptr_q[WORD_W-1:0]));
endmodule

// File: rtl/cbuf_dma_cnt.sv
module cbuf_dma_cnt
  import cbuf_dma_pkg::*;
#(
  parameter int unsigned CHUNK = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [PTR_W-1:0] cur_ptr_o,
  output logic             last_o,
  output logic             chunk_end_o
);
  localparam int unsigned     CW      = $clog2(CHUNK + 1);
  localparam logic [CW-1:0]   CHUNK_C = CW'(CHUNK);
  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK);

  logic [PTR_W-1:0] cur_q;
  logic [LEN_W-1:0] rem_q, rem_dec;
  logic [CW-1:0]    chunk_q;

  function automatic logic [CW-1:0] chunk_of(input logic [LEN_W-1:0] n);
    return (n > CHUNK_L) ? CHUNK_C : n[CW-1:0];
  endfunction

  assign rem_dec = rem_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      rem_q   <= '0;
      chunk_q <= '0;
    end else if (load_i) begin
      cur_q   <= ptr_i;
      rem_q   <= len_i;
      chunk_q <= chunk_of(len_i);
    end else if (step_i) begin
      cur_q   <= cur_q + 1'b1;
      rem_q   <= rem_dec;
      chunk_q <= (chunk_q == CW'(1)) ? chunk_of(rem_dec) : chunk_q - 1'b1;
    end
  end

  assign cur_ptr_o   = cur_q;
  assign last_o      = (rem_q == LEN_W'(1));
  assign chunk_end_o = (chunk_q == CW'(1));

  a_r3_chunk_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chunk_q <= CHUNK_C);
  a_r3_chunk_le_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LEN_W'(chunk_q) <= rem_q);
endmodule

// File: rtl/cbuf_dma_ctrl.sv
module cbuf_dma_ctrl
  import cbuf_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_tx_i,
  input  logic              start_mem_i,
  input  logic              len_zero_i,
  input  logic              last_i,
  input  logic              chunk_end_i,
  input  logic              mem_rsp_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              tx_ready_i,
  input  logic              rx_empty_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              load_o,
  output logic              step_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              rx_pop_o,
  output logic              idle_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_rx_empty_o
);
  state_e            state_q, state_d;
  logic [BYTE_W-1:0] tx_q;
  logic              cap_rd;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    cap_rd  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_tx_i || start_mem_i) begin
          load_o = 1'b1;
          if (len_zero_i)       state_d = ST_DONE;
          else if (start_tx_i)  state_d = ST_W_REQ;
          else                  state_d = ST_R_CHK;
        end
      end
      ST_W_REQ: begin
        if (mem_rsp_i) begin
          cap_rd  = 1'b1;
          state_d = ST_W_TX;
        end
      end
      ST_W_TX: begin
        if (tx_ready_i) begin
          step_o = 1'b1;
          if (last_i)           state_d = ST_DONE;
          else if (chunk_end_i) state_d = ST_W_NEXT;
          else                  state_d = ST_W_REQ;
        end
      end
      ST_W_NEXT: state_d = ST_W_REQ;
      ST_R_CHK:  state_d = rx_empty_i ? ST_DONE : ST_R_REQ;
      ST_R_REQ: begin
        if (mem_rsp_i) begin
          step_o  = 1'b1;
          state_d = last_i ? ST_DONE : ST_R_CHK;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cap_rd) tx_q <= mem_rdata_i;
    end
  end

  assign mem_req_o       = (state_q == ST_W_REQ) || (state_q == ST_R_REQ);
  assign mem_we_o        = (state_q == ST_R_REQ);
  assign mem_wdata_o     = (state_q == ST_R_REQ) ? rx_data_i : '0;
  assign rx_pop_o        = (state_q == ST_R_REQ) && mem_rsp_i;
  assign tx_valid_o      = (state_q == ST_W_TX);
  assign tx_data_o       = tx_q;
  assign idle_o          = (state_q == ST_IDLE);
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = (state_q == ST_DONE);
  assign done_rx_empty_o = done_o && rx_empty_i;

  a_r4_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  a_r5_pop_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> !rx_empty_i && mem_we_o);
  a_r7_zero_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_tx_i || start_mem_i) && idle_o && len_zero_i |=> done_o && !mem_req_o);
  a_r6_stop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_R_CHK && rx_empty_i |=> done_o);
endmodule

// File: rtl/cbuf_dma.sv
module cbuf_dma
  import cbuf_dma_pkg::*;
#(
  parameter int unsigned CHUNK = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              done_rx_empty_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [PTR_W-1:0]  mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic              mem_rsp_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_ready_i,
  input  logic              rx_empty_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_pop_o
);
  logic idle, start_tx, start_mem, load, step, last, chunk_end;

  cbuf_dma_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .idle_i      (idle),
    .ptr_o       (ptr_o),
    .len_o       (len_o),
    .start_tx_o  (start_tx),
    .start_mem_o (start_mem)
  );

  cbuf_dma_cnt #(.CHUNK(CHUNK)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .step_i      (step),
    .ptr_i       (ptr_o),
    .len_i       (len_o),
    .cur_ptr_o   (mem_addr_o),
    .last_o      (last),
    .chunk_end_o (chunk_end)
  );

  cbuf_dma_ctrl u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_tx_i      (start_tx),
    .start_mem_i     (start_mem),
    .len_zero_i      (len_o == '0),
    .last_i          (last),
    .chunk_end_i     (chunk_end),
    .mem_rsp_i       (mem_rsp_i),
    .mem_rdata_i     (mem_rdata_i),
    .tx_ready_i      (tx_ready_i),
    .rx_empty_i      (rx_empty_i),
    .rx_data_i       (rx_data_i),
    .load_o          (load),
    .step_o          (step),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_wdata_o     (mem_wdata_o),
    .tx_valid_o      (tx_valid_o),
    .tx_data_o       (tx_data_o),
    .rx_pop_o        (rx_pop_o),
    .idle_o          (idle),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .done_rx_empty_o (done_rx_empty_o)
  );

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));
  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !tx_valid_o && !rx_pop_o);
endmodule

// File: tb/cbuf_dma_tb_top.sv
module cbuf_dma_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        reg_we_i;
  logic [5:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [63:0] ptr_o, mem_addr_o;
  logic [31:0] len_o;
  logic        busy_o, done_o, done_rx_empty_o;
  logic        mem_req_o, mem_we_o, mem_rsp_i;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic        tx_valid_o, tx_ready_i;
  logic [7:0]  tx_data_o;
  logic        rx_empty_i, rx_pop_o;
  logic [7:0]  rx_data_i;

  int n_tests = 0, n_fail = 0, acc_cnt = 0, cyc = 0;
  bit pend_pop = 0, force_stall = 0, finished = 0;
  logic [7:0]  tx_exp[$];
  logic [71:0] wr_exp[$];
  logic [7:0]  rx_q[$];

  always #4 clk_i = ~clk_i;

  cbuf_dma #(.CHUNK(16)) dut_i (.*);

  function automatic logic [7:0] mem_fn(input logic [63:0] a);
    return a[7:0] ^ a[15:8] ^ a[39:32] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // monitor / memory and FIFO model
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      pend_pop = 0; mem_rsp_i = 0; tx_ready_i = 0;
      rx_empty_i = 1; rx_data_i = 0; mem_rdata_i = 0;
    end else begin
      bit exp_pop;
      logic [7:0] e;
      logic [71:0] w;
      if (pend_pop) begin
        if (rx_q.size() > 0) rx_q.delete(0);
        pend_pop = 0;
      end
      rx_empty_i = (rx_q.size() == 0);
      rx_data_i  = rx_empty_i ? 8'h00 : rx_q[0];
      tx_ready_i = force_stall ? 1'b0 : (($urandom % 4) != 0);
      if (tx_valid_o && tx_ready_i) begin
        if (tx_exp.size() == 0) chk(0, "R2", "unexpected tx byte", {64'h0, tx_data_o}, 0);
        else begin
          e = tx_exp.pop_front();
          chk(tx_data_o == e, "R2", "tx byte", {64'h0, tx_data_o}, {64'h0, e});
        end
      end
      mem_rsp_i = 0;
      exp_pop = 0;
      if (mem_req_o && (($urandom % 3) != 0)) begin
        mem_rsp_i = 1;
        acc_cnt++;
        if (mem_we_o) begin
          exp_pop = 1;
          if (wr_exp.size() == 0)
            chk(0, "R8", "unexpected memory write", {mem_addr_o, mem_wdata_o}, 0);
          else begin
            w = wr_exp.pop_front();
            chk({mem_addr_o, mem_wdata_o} == w, "R5", "write addr/data",
                {mem_addr_o, mem_wdata_o}, w);
          end
        end else begin
          mem_rdata_i = mem_fn(mem_addr_o);
        end
      end
      #1;
      if (exp_pop || rx_pop_o)
        chk(rx_pop_o == exp_pop, "R5", "pop with write response", {71'h0, rx_pop_o}, {71'h0, exp_pop});
      pend_pop = rx_pop_o;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc >= 150000 && !finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0;
  endtask

  task automatic run(input logic [31:0] cmd, input logic [63:0] ptr,
                     input logic [31:0] len, input bit inject, input string rq);
    int n, acc0, t;
    bit exp_empty;
    logic [63:0] fptr;
    logic [31:0] flen;
    if (cmd == 32'd2) begin
      for (int i = 0; i < int'(len); i++) tx_exp.push_back(mem_fn(ptr + 64'(i)));
      n = int'(len);
      exp_empty = (rx_q.size() == 0);
    end else begin
      n = (rx_q.size() < int'(len)) ? rx_q.size() : int'(len);
      for (int i = 0; i < n; i++) wr_exp.push_back({ptr + 64'(i), rx_q[i]});
      exp_empty = (rx_q.size() <= int'(len));
    end
    reg_wr(6'h10, ptr[31:0]);
    reg_wr(6'h18, ptr[63:32]);
    reg_wr(6'h14, len);
    acc0 = acc_cnt;
    reg_wr(6'h08, cmd);
    chk(busy_o == 1'b1, "R8", "busy after start", {71'h0, busy_o}, 1);
    if (len == 0) chk(done_o == 1'b1, "R7", "done right after zero-length start", {71'h0, done_o}, 1);
    fptr = ptr; flen = len;
    if (inject) begin
      reg_wr(6'h08, 32'd3);
      reg_wr(6'h10, 32'hDEAD0000);
      reg_wr(6'h14, 32'd7);
      fptr = 64'h0000_0000_DEAD_0000;
      flen = 32'd7;
    end
    t = 0;
    while (!done_o && t < 20000) begin @(negedge clk_i); t++; end
    chk(done_o == 1'b1, rq, "transfer completes", {71'h0, done_o}, 1);
    #1;
    chk(done_rx_empty_o == exp_empty, "R9", "fifo empty flag at done",
        {71'h0, done_rx_empty_o}, {71'h0, exp_empty});
    chk(acc_cnt - acc0 == n, rq, "memory access count", 72'(acc_cnt - acc0), 72'(n));
    chk(tx_exp.size() == 0 && wr_exp.size() == 0, rq, "all expected items seen",
        72'(tx_exp.size() + wr_exp.size()), 0);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R8", "done one cycle then idle", {70'h0, done_o, busy_o}, 0);
    chk(ptr_o == fptr && len_o == flen, "R10", "stored registers after transfer",
        {ptr_o, len_o[7:0]}, {fptr, flen[7:0]});
  endtask

  initial begin
    rst_ni = 0; reg_we_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R12 reset state
    chk(!busy_o && !done_o && !mem_req_o && !tx_valid_o, "R12", "outputs idle after reset",
        {68'h0, busy_o, done_o, mem_req_o, tx_valid_o}, 0);
    chk(ptr_o == 0 && len_o == 0, "R12", "registers zero after reset", {ptr_o, len_o[7:0]}, 0);
    // R1 pointer composition
    reg_wr(6'h10, 32'h1234_5678);
    reg_wr(6'h18, 32'h0000_ABCD);
    chk(ptr_o == 64'h0000_ABCD_1234_5678, "R1", "low then high", {8'h0, ptr_o}, 72'h0000_ABCD_1234_5678);
    reg_wr(6'h10, 32'h9);
    chk(ptr_o == 64'h9, "R1", "low write clears high", {8'h0, ptr_o}, 72'h9);
    reg_wr(6'h18, 32'h77);
    chk(ptr_o == 64'h0000_0077_0000_0009, "R1", "high write keeps low", {8'h0, ptr_o}, 72'h77_0000_0009);
    reg_wr(6'h14, 32'hCAFE_0001);
    chk(len_o == 32'hCAFE_0001, "R1", "length register", {40'h0, len_o}, 72'hCAFE_0001);
    // R2 short memory-to-console
    run(32'd2, 64'h0000_0000_0000_1000, 32'd5, 0, "R2");
    // R3 multi-chunk across the 32-bit carry
    run(32'd2, 64'h0000_0000_FFFF_FFF0, 32'd40, 0, "R3");
    // R4 stall
    force_stall = 1;
    fork
      run(32'd2, 64'h0000_0002_0000_0100, 32'd6, 0, "R4");
      begin
        logic [7:0] d;
        while (!tx_valid_o) @(negedge clk_i);
        d = tx_data_o;
        repeat (8) @(negedge clk_i);
        chk(tx_valid_o && tx_data_o == d, "R4", "byte held under stall",
            {63'h0, tx_valid_o, tx_data_o}, {63'h0, 1'b1, d});
        force_stall = 0;
      end
    join
    // R6 FIFO runs dry before length
    for (int i = 0; i < 4; i++) rx_q.push_back(8'hA0 + 8'(i));
    run(32'd3, 64'h0000_0000_0000_2000, 32'd10, 0, "R6");
    chk(rx_q.size() == 0, "R6", "fifo drained", 72'(rx_q.size()), 0);
    // R5 length ends first
    for (int i = 0; i < 8; i++) rx_q.push_back(8'h30 + 8'(i));
    run(32'd3, 64'h0000_0003_FFFF_FFFE, 32'd3, 0, "R5");
    chk(rx_q.size() == 5, "R5", "fifo bytes left", 72'(rx_q.size()), 5);
    // R7 zero length both directions
    run(32'd3, 64'h0000_0000_0000_3000, 32'd0, 0, "R7");
    chk(rx_q.size() == 5, "R7", "no pop on zero length", 72'(rx_q.size()), 5);
    run(32'd2, 64'h0000_0000_0000_3000, 32'd0, 0, "R7");
    // R8/R10 command and register writes while busy
    rx_q.delete();
    rx_q.push_back(8'h11); rx_q.push_back(8'h22);
    @(negedge clk_i);
    run(32'd2, 64'h0000_0000_0000_4000, 32'd20, 1, "R8");
    chk(rx_q.size() == 2, "R8", "command while busy ignored", 72'(rx_q.size()), 2);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule